// File: doc/BRIEF.md
# Autobaud Single-Wire Serial Transceiver

This block is a half-duplex byte transceiver for a single shared line that is pulled up externally and only ever pulled low by its users. It does not need to be told the baud rate. After reset it watches the line. The first character a host sends must be 80H. With the start bit and the low data bits, that character holds the line low for exactly eight bit times. The block counts that low interval in system clocks, divides by eight and uses the result as its bit period from then on. The learned period is kept until the next reset.

Once the period is known, the receiver takes frames of one start bit, eight data bits (least significant first) and one stop bit. It samples each bit in its middle and delivers each good byte as a one-cycle strobe. The transmitter sends a byte in the same format through a valid/ready handshake. It drives the line only through a pull-down enable. The receiver returns to idle at the middle of the stop bit, so a reply can begin on the very next cycle after a received byte. While the block transmits, the receiver ignores the line, so the block never hears its own frame.

The line input is asynchronous and passes through a synchronizer before it is used. Command handling on top of the byte stream belongs to the user of this block.

Top module: `swab_xcvr`

## Requirements
- R1: While reset is held and on the first cycle after it, `line_pull`, `baud_locked`, `tx_ready`, `rx_valid` and `rx_frame_err` are all 0.
- R2: The first low interval of at least `MIN_LOW` clocks sets the bit period to floor(interval/8) clocks. `baud_locked` rises 3 cycles after the line goes back high, counted from the first edge at which the high level is present on `line_in`. It then stays 1 until reset.
- R3: A low interval shorter than `MIN_LOW` clocks is discarded. `baud_locked` stays 0 and the next low interval is measured afresh.
- R4: Before `baud_locked` is 1, `tx_ready` is 0, `tx_valid` has no effect, `line_pull` stays 0 and no byte or framing error is reported.
- R5: A frame is a low start bit, 8 data bits with bit 0 first, and a high stop bit. Detection happens 3 clock edges after the line falls, and each bit is sampled period/2 + k*period clocks after detection (k = 0 for start, 9 for stop). If the stop bit is high, `rx_valid` is 1 for exactly one cycle after the stop sample, with the byte on `rx_data`.
- R6: If the stop bit samples low, `rx_frame_err` pulses for one cycle in place of `rx_valid`, and the byte is dropped. The receiver then waits for the line to return high before looking for a new start bit, and `tx_ready` is 0 during that wait.
- R7: A low pulse that is already high again when the start bit is sampled is treated as noise. Nothing is reported and the receiver returns to idle.
- R8: A transmitted frame drives `line_pull` = 1 for the start bit, `line_pull` = NOT data bit i for data bits 0 to 7 in that order, and 0 for the stop bit. Each bit lasts exactly one bit period, and the first bit begins on the cycle after the accepting edge.
- R9: A byte is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 1 only while the block is locked, not transmitting, and its receiver is idle.
- R10: On the cycle in which `rx_valid` is 1, `tx_ready` is already 1, so a reply may start immediately after the stop-bit sample.
- R11: While a frame is being transmitted, the receiver reports neither a byte nor a framing error, even though its own start bit pulls the line low.
- R12: `line_pull` is 1 only during a transmission, and `tx_ready` is never 1 at the same time as `line_pull`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Level of the shared line (asynchronous) |
| line_pull | output | 1 | 1 pulls the shared line low; 0 releases it |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_frame_err | output | 1 | One-cycle strobe: a frame ended with a low stop bit |
| baud_locked | output | 1 | Bit period has been learned |

## Verification
On every cycle, the assertions check that the lock is sticky and respects the minimum period, and that nothing moves before lock. They also check that a pull only happens inside a transmission, that the ready signal and the pull never overlap, that receive strobes are single-cycle and mutually exclusive, and that the receiver stays silent while the block transmits. The exact length of the learned bit period, the mid-bit sampling instants, the LSB-first bit order on both paths, the rejection of short pulses and noise, the recovery after a framing error, and the immediate reply after a received stop bit depend on whole scenarios. Only the bench shows these, by comparing every output on every clock with its own timing model.

// File: rtl/swab_pkg.sv
// Shared types and constants for the autobaud single-wire transceiver.
package swab_pkg;

    // Frame layout: one start bit, eight data bits, one stop bit.
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    // Index of the stop bit inside a frame (start bit is index 0).
    localparam int STOP_IDX   = FRAME_BITS - 1;

    // Bit-period learning states.
    typedef enum logic [1:0] {
        AB_WAIT = 2'd0,   // line idle, waiting for the first low level
        AB_MEAS = 2'd1,   // counting the low interval
        AB_LOCK = 2'd2    // period learned, held until reset
    } ab_state_t;

    // Receiver states.
    typedef enum logic [1:0] {
        RX_IDLE      = 2'd0, // waiting for a start bit
        RX_FRAME     = 2'd1, // sampling bits of a frame
        RX_WAIT_HIGH = 2'd2  // after a bad stop bit, wait for the line to rise
    } rx_state_t;

endpackage

// File: rtl/swab_sync.sv
// Synchronizer for the asynchronous line level.
// Assumes: the line idles high, so every stage resets to 1.
// The number of stages is a parameter; one stage is allowed but not advised.
module swab_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_single
            // Capture the line in a single flop.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= 1'b1;
                else        ff <= d;
            end
        end else begin : g_chain
            // Shift the line level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= '1;
                else        ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];

endmodule

// File: rtl/swab_baud_meas.sv
// Bit-period learner.
// It measures the first low interval of the synchronized line in clocks.
// An interval of at least MIN_LOW clocks is taken as eight bit times, and
// the period (interval / 8) is kept until reset. Shorter intervals are
// discarded and measurement starts over.
// Assumes: MIN_LOW >= 32, so the learned period is at least 4 clocks.
module swab_baud_meas
    import swab_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int MIN_LOW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    output logic             locked,
    output logic [CNT_W-4:0] period
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOW);

    ab_state_t        st;
    logic [CNT_W-1:0] cnt;

    // Count the low interval and latch the period when the line rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= AB_WAIT;
            cnt    <= '0;
            period <= '0;
        end else begin
            case (st)
                AB_WAIT: begin
                    if (!line_s) begin
                        st  <= AB_MEAS;
                        cnt <= CNT_W'(1);
                    end
                end
                AB_MEAS: begin
                    if (!line_s) begin
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    end else if (cnt >= CNT_MIN) begin
                        period <= cnt[CNT_W-1:3];
                        st     <= AB_LOCK;
                    end else begin
                        st <= AB_WAIT;
                    end
                end
                AB_LOCK: st <= AB_LOCK;
                default: st <= AB_WAIT;
            endcase
        end
    end

    assign locked = (st == AB_LOCK);

endmodule

// File: rtl/swab_rx.sv
// Frame receiver.
// After a start edge it samples the synchronized line in the middle of
// each bit. It shifts data in LSB first and checks the stop bit. A good
// frame gives a one-cycle rx_valid; a low stop bit gives a one-cycle
// rx_err and a wait for the line to rise.
// Assumes: period >= 4 clocks and is stable while enable is 1.
module swab_rx
    import swab_pkg::*;
#(
    parameter int PER_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic             enable,
    input  logic             ignore,
    input  logic [PER_W-1:0] period,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_err,
    output logic             rx_idle
);

    rx_state_t        st;
    logic [PER_W-1:0] tmr;
    logic [3:0]       idx;
    logic [7:0]       sh;

    // Detect the start edge, time each mid-bit sample, and assemble the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            tmr      <= '0;
            idx      <= '0;
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (enable && !ignore && !line_s) begin
                        st  <= RX_FRAME;
                        tmr <= (period >> 1) - 1'b1;
                        idx <= '0;
                    end
                end
                RX_FRAME: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else begin
                        tmr <= period - 1'b1;
                        idx <= idx + 4'd1;
                        if (idx == 4'd0) begin
                            if (line_s) st <= RX_IDLE;   // noise, not a start bit
                        end else if (idx <= 4'(DATA_BITS)) begin
                            sh <= {line_s, sh[7:1]};
                        end else if (line_s) begin
                            rx_valid <= 1'b1;
                            rx_data  <= sh;
                            st       <= RX_IDLE;
                        end else begin
                            rx_err <= 1'b1;
                            st     <= RX_WAIT_HIGH;
                        end
                    end
                end
                RX_WAIT_HIGH: begin
                    if (line_s) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign rx_idle = (st == RX_IDLE);

endmodule

// File: rtl/swab_tx.sv
// Frame transmitter.
// It sends start, eight data bits LSB first, and stop, each for one bit
// period. The line is only pulled low (pull = 1 for a 0 bit) and released
// otherwise.
// Assumes: period >= 1 and stays stable during a frame.
module swab_tx
    import swab_pkg::*;
#(
    parameter int PER_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    input  logic             start,
    input  logic [7:0]       data,
    output logic             pull,
    output logic             busy
);

    logic [PER_W-1:0] tmr;
    logic [3:0]       idx;
    logic [8:0]       sh;

    // Load a byte on start, then step through the frame bits one period each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull <= 1'b0;
            busy <= 1'b0;
            tmr  <= '0;
            idx  <= '0;
            sh   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                pull <= 1'b1;
                tmr  <= period - 1'b1;
                idx  <= '0;
                sh   <= {1'b1, data};
            end
        end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
        end else if (idx == 4'(STOP_IDX)) begin
            busy <= 1'b0;
            pull <= 1'b0;
        end else begin
            idx  <= idx + 4'd1;
            pull <= ~sh[0];
            sh   <= {1'b1, sh[8:1]};
            tmr  <= period - 1'b1;
        end
    end

endmodule

// File: rtl/swab_xcvr.sv
// Autobaud single-wire transceiver, top level.
// It synchronizes the line, learns the bit period from the first 80H
// character, and then receives and transmits 8N1 frames half duplex on
// one open-drain line. Transmit is gated by the receiver being idle. The
// receiver is muted while transmitting.
// Assumes: an external pull-up on the line, MIN_LOW >= 32.
module swab_xcvr #(
    parameter int CNT_W       = 20,
    parameter int MIN_LOW     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic       line_pull,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_frame_err,
    output logic       baud_locked
);

    localparam int PER_W = CNT_W - 3;

    logic             line_s;
    logic [PER_W-1:0] bit_period;
    logic             tx_busy;
    logic             rx_idle;
    logic             tx_go;

    swab_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    swab_baud_meas #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) u_meas (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (line_s),
        .locked (baud_locked),
        .period (bit_period)
    );

    swab_rx #(.PER_W(PER_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .enable   (baud_locked),
        .ignore   (tx_busy),
        .period   (bit_period),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_err   (rx_frame_err),
        .rx_idle  (rx_idle)
    );

    // Accept a byte only when locked, idle on both directions.
    assign tx_ready = baud_locked && !tx_busy && rx_idle;
    assign tx_go    = tx_valid && tx_ready;

    swab_tx #(.PER_W(PER_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (bit_period),
        .start  (tx_go),
        .data   (tx_data),
        .pull   (line_pull),
        .busy   (tx_busy)
    );

endmodule

// File: rtl/swab_xcvr_chk.sv
// Property checker for swab_xcvr, attached with bind below.
module swab_xcvr_chk #(
    parameter int CNT_W   = 20,
    parameter int MIN_LOW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_pull,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_frame_err,
    input logic             baud_locked,
    input logic             tx_busy,
    input logic [CNT_W-4:0] bit_period
);

    assert_locked_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        baud_locked |=> baud_locked);

    assert_period_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_locked |-> (bit_period >= (CNT_W-3)'(MIN_LOW / 8)));

    assert_unlocked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_locked |-> (!tx_ready && !line_pull && !rx_valid && !rx_frame_err));

    assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_err));

    assert_pull_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !line_pull);

    assert_accept_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (line_pull && tx_busy));

    assert_rx_muted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> (!rx_valid && !rx_frame_err));

    assert_pull_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> !tx_ready);

endmodule

bind swab_xcvr swab_xcvr_chk #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_pull    (line_pull),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .baud_locked  (baud_locked),
    .tx_busy      (tx_busy),
    .bit_period   (bit_period)
);

// File: tb/swab_xcvr_test.sv
// Bench for swab_xcvr: a timing model of the line protocol, compared
// against every output on every clock.
module swab_xcvr_test;

    localparam int P    = 40;      // host bit period in clocks
    localparam int HALF = P / 2;
    localparam int MINL = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       line;
    logic       line_pull;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_err;
    logic       baud_locked;

    always #4 clk = ~clk;   // 125 MHz

    // Open-drain line with pull-up: low if anyone pulls.
    assign line = !(host_low || line_pull);

    swab_xcvr #(.CNT_W(20), .MIN_LOW(MINL), .SYNC_STAGES(2)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line),
        .line_pull    (line_pull),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .baud_locked  (baud_locked)
    );

    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    int         lock_cyc = 1 << 30;
    int         tx_start = -1000000;
    logic [7:0] tx_byte = 8'h00;
    int         nrx = 0;
    int         exp_v[$];
    logic [7:0] exp_d[$];
    int         exp_e[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // Expected pull level from the model of the last accepted transmit.
    function automatic logic model_pull(input int c);
        int i;
        if (c < tx_start || c >= tx_start + 10 * P) return 1'b0;
        i = (c - tx_start) / P;
        if (i == 0) return 1'b1;
        if (i <= 8) return !tx_byte[i-1];
        return 1'b0;
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        logic ev, ee, ep;
        ep = model_pull(cyc);
        chk(line_pull === ep, "R8 line_pull", int'(line_pull), int'(ep));
        chk(baud_locked === (cyc >= lock_cyc), "R2 baud_locked", int'(baud_locked), int'(cyc >= lock_cyc));
        chk(!(line_pull && tx_ready), "R12 pull with ready", int'(tx_ready), 0);
        ev = (exp_v.size() > 0) && (exp_v[0] == cyc);
        ee = (exp_e.size() > 0) && (exp_e[0] == cyc);
        chk(rx_valid === ev, "R5 R11 rx_valid", int'(rx_valid), int'(ev));
        chk(rx_frame_err === ee, "R6 R11 rx_frame_err", int'(rx_frame_err), int'(ee));
        if (ev) begin
            chk(rx_data === exp_d[0], "R5 rx_data", int'(rx_data), int'(exp_d[0]));
            void'(exp_v.pop_front());
            void'(exp_d.pop_front());
        end
        if (ee) void'(exp_e.pop_front());
        if (rx_valid === 1'b1 || rx_frame_err === 1'b1) nrx++;
    end

    // Learning pulse of len clocks; it locks when len >= MINL.
    task automatic send_low(input int len);
        @(posedge clk); #1;
        if (len >= MINL) lock_cyc = cyc + len + 3;
        host_low = 1'b1;
        repeat (len) @(posedge clk);
        #1 host_low = 1'b0;
    endtask

    // One host frame; stop_hi = 0 holds the stop bit low and releases later.
    task automatic send_frame(input logic [7:0] b, input bit stop_hi);
        @(posedge clk); #1;
        if (stop_hi) begin
            exp_v.push_back(cyc + 3 + HALF + 9 * P);
            exp_d.push_back(b);
        end else begin
            exp_e.push_back(cyc + 3 + HALF + 9 * P);
        end
        for (int i = 0; i < 10; i++) begin
            if (i == 0)     host_low = 1'b1;
            else if (i < 9) host_low = !b[i-1];
            else            host_low = !stop_hi;
            repeat (P) @(posedge clk);
            #1;
        end
        if (!stop_hi) begin
            repeat (P) @(posedge clk);
            #1;
            chk(tx_ready == 1'b0, "R6 ready low while line held low", int'(tx_ready), 0);
            host_low = 1'b0;
            repeat (P) @(posedge clk);
            #1;
        end
        host_low = 1'b0;
    endtask

    // Start a transmit on the next edge; the model records the accept edge.
    task automatic tx_send(input logic [7:0] b);
        @(posedge clk); #1;
        tx_start = cyc + 1;
        tx_byte  = b;
        tx_data  = b;
        tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int seen;
        repeat (3) @(posedge clk);
        #1;
        chk(line_pull == 1'b0 && baud_locked == 1'b0, "R1 reset pull/lock", int'({line_pull, baud_locked}), 0);
        chk(tx_ready == 1'b0 && rx_valid == 1'b0 && rx_frame_err == 1'b0, "R1 reset handshake",
            int'({tx_ready, rx_valid, rx_frame_err}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(tx_ready == 1'b0 && baud_locked == 1'b0, "R1 first cycle after reset", int'({tx_ready, baud_locked}), 0);

        // R4: a request before lock is ignored (monitor expects no pull).
        tx_data  = 8'h5A;
        tx_valid = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(tx_ready == 1'b0, "R4 ready before lock", int'(tx_ready), 0);
        tx_valid = 1'b0;
        repeat (10) @(posedge clk);

        // R3: too short a learning pulse.
        send_low(20);
        repeat (20) @(posedge clk);
        #1 chk(baud_locked == 1'b0, "R3 short pulse rejected", int'(baud_locked), 0);

        // R2: the proper 80H character (8 low bit times, then D7 and stop high).
        send_low(8 * P);
        repeat (2 * P) @(posedge clk);
        #1 chk(baud_locked == 1'b1, "R2 locked after 80H", int'(baud_locked), 1);

        // R5: several byte patterns.
        send_frame(8'hA5, 1'b1);
        send_frame(8'h3C, 1'b1);
        send_frame(8'h00, 1'b1);
        send_frame(8'hFF, 1'b1);
        repeat (P) @(posedge clk);
        #1 chk(nrx == 4, "R5 four bytes received", nrx, 4);

        // R7: a glitch shorter than half a bit.
        seen = nrx;
        @(posedge clk); #1 host_low = 1'b1;
        repeat (5) @(posedge clk);
        #1 host_low = 1'b0;
        repeat (12 * P) @(posedge clk);
        #1 chk(nrx == seen, "R7 glitch ignored", nrx, seen);
        send_frame(8'h5A, 1'b1);

        // R6: low stop bit, then recovery.
        send_frame(8'h55, 1'b0);
        send_frame(8'h81, 1'b1);
        repeat (P) @(posedge clk);

        // R8, R9, R11: transmit a byte.
        seen = nrx;
        #1 chk(tx_ready == 1'b1, "R9 ready when idle and locked", int'(tx_ready), 1);
        tx_send(8'h96);
        repeat (P) @(posedge clk);
        #1 chk(tx_ready == 1'b0, "R9 ready low while sending", int'(tx_ready), 0);
        repeat (10 * P) @(posedge clk);
        #1 chk(nrx == seen, "R11 own frame not received", nrx, seen);

        // R10: reply right after a received stop-bit sample.
        fork
            send_frame(8'h11, 1'b1);
            begin
                @(negedge clk);
                while (rx_valid !== 1'b1) @(negedge clk);
                chk(tx_ready == 1'b1, "R10 ready with rx_valid", int'(tx_ready), 1);
                tx_send(8'hE7);
            end
        join
        repeat (11 * P) @(posedge clk);
        #1 chk(exp_v.size() == 0 && exp_e.size() == 0, "R5 R6 all expected strobes seen",
               exp_v.size() + exp_e.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule